// File: doc/BRIEF.md
# Four-Channel Concatenable Pulse Width Modulator

This block produces four pulse width modulated outputs, one per channel, from a single system clock. Every channel owns an 8-bit counter together with a period setting and a duty setting. It drives its pin at an active level while the count is below duty and at the opposite level for the rest of the period. A polarity bit per channel decides which level counts as active. Each channel takes its count enable from one of three tick sources. Two of them come from a shared power-of-two prescaler. The third is a further scaled version of the first.

Software writes configuration through a simple write-only port of address, data and strobe. Period and duty writes land in buffer registers. A running channel picks them up only when its counter wraps, so a new setting never cuts a period short. A stopped channel follows its buffers at once. Adjacent channels (0 with 1, 2 with 3) can be fused into one 16-bit channel for longer periods or finer duty steps.

Top module: `pwm4_unit`

## Requirements
- R1: The prescale register at address 3 holds the A exponent in bits [2:0] and the B exponent in bits [6:4]. Tick A fires once every 2^A system clocks and tick B once every 2^B. The scale register at address 4 holds M, and tick S fires once every 2*(M+1) ticks of A.
- R2: The select register at address 5 gives channel i two bits at [2i+1:2i]. Code 0 counts on tick A, code 1 on tick B and code 2 on tick S.
- R3: A running channel counts its ticks from 0 to period-1 and then returns to 0. Its output is active while the count is below duty. The period of channel i is written at address 8+i and its duty at address 12+i.
- R4: A duty of 0 keeps the output at the inactive level for every cycle.
- R5: A duty greater than or equal to the period keeps the output at the active level for every cycle.
- R6: Bit i of the polarity register at address 1 selects the active level of channel i. Value 1 means the output starts high and drops when the count reaches duty. Value 0 inverts both levels.
- R7: A period or duty write to a running channel has no effect on its output until the counter next wraps. From that wrap on, the new value governs the channel.
- R8: Bit i of the enable register at address 0 runs channel i. A stopped channel holds its count at 0, drives its inactive level and copies its buffers into its working settings on every cycle.
- R9: Bit p of the fuse register at address 2 joins channels 2p and 2p+1 into one 16-bit channel. The high byte of count, period and duty belongs to channel 2p. The enable, select and polarity of channel 2p+1 govern it, and the result appears on pin 2p+1. Pin 2p then holds its own inactive level.
- R10: After reset every register is zero, so all channels are stopped with polarity 0 and every pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 4 | Modulated outputs, bit i for channel i |

## Verification
A corrupted counter or working setting shows up within one period of the affected channel. It appears as a changed count of active cycles or of rising edges in a window of whole periods. A buffer that leaks into a running channel too early shows up in the cycle right after the write, because the output level no longer matches the old duty. A prescaler or scale counter at the wrong rate changes the number of rising edges per window. A fused pair that is wired wrongly either lets pin 2p move or turns the 256-tick period into a constant level, within the first period.

// File: rtl/pwm4_pkg.sv
// Package: shared encodings and the fixed control-register addresses of the
// four-channel modulator. Assumes the control registers fit in one byte.
package pwm4_pkg;

    // Tick source chosen per channel
    typedef enum logic [1:0] {
        SRC_A     = 2'd0,
        SRC_B     = 2'd1,
        SRC_S     = 2'd2,
        SRC_SPARE = 2'd3
    } clk_src_e;

    // Control register addresses; period and duty buffers follow at 8 and up
    localparam logic [3:0] ADR_ENABLE = 4'h0;
    localparam logic [3:0] ADR_POLAR  = 4'h1;
    localparam logic [3:0] ADR_FUSE   = 4'h2;
    localparam logic [3:0] ADR_PRESC  = 4'h3;
    localparam logic [3:0] ADR_SCALE  = 4'h4;
    localparam logic [3:0] ADR_SELECT = 4'h5;

    localparam int PER_BASE = 8;

endpackage

// File: rtl/pwm4_prescaler.sv
// Module: pwm4_prescaler
// Produces three single-cycle tick enables from the system clock: tick A
// every 2^div_a cycles, tick B every 2^div_b cycles, and tick S every
// 2*(scale+1) ticks of A. Assumes the exponents are at most 2^DIV_W-1.
module pwm4_prescaler #(
    parameter int DIV_W   = 3,
    parameter int SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIV_W-1:0]   div_a,
    input  logic [DIV_W-1:0]   div_b,
    input  logic [SCALE_W-1:0] scale,
    output logic               tick_a,
    output logic               tick_b,
    output logic               tick_s
);

    localparam int CNT_W = (1 << DIV_W) - 1;
    localparam int S_W   = SCALE_W + 1;

    logic [CNT_W-1:0] base_cnt;
    logic [CNT_W-1:0] mask_a;
    logic [CNT_W-1:0] mask_b;
    logic [S_W-1:0]   s_cnt;
    logic [S_W-1:0]   s_last;

    // Free-running divider counter shared by A and B
    always_ff @(posedge clk) begin
        if (!rst_n) base_cnt <= '0;
        else        base_cnt <= base_cnt + CNT_W'(1);
    end

    // Low-bit masks selecting how many counter bits must be all ones
    always_comb begin
        mask_a = (CNT_W'(1) << div_a) - CNT_W'(1);
        mask_b = (CNT_W'(1) << div_b) - CNT_W'(1);
        s_last = {scale, 1'b1};
    end

    assign tick_a = (base_cnt & mask_a) == mask_a;
    assign tick_b = (base_cnt & mask_b) == mask_b;
    assign tick_s = tick_a && (s_cnt == s_last);

    // Counts A ticks up to 2*scale+1 and restarts, giving the S rate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_cnt <= '0;
        end else if (tick_a) begin
            if (s_cnt >= s_last) s_cnt <= '0;
            else                 s_cnt <= s_cnt + S_W'(1);
        end
    end

endmodule

// File: rtl/pwm4_pair.sv
// Module: pwm4_pair
// Two adjacent modulator lanes. Index 0 is the lower-numbered channel,
// index 1 the higher. With fuse set, the lanes form one 16-bit channel
// whose high byte sits in lane 0, governed by lane 1's enable, tick and
// polarity and driven on pin 1. Assumes tick inputs are already selected.
module pwm4_pair #(
    parameter int BYTE_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fuse,
    input  logic [1:0]             en,
    input  logic [1:0]             pol,
    input  logic [1:0]             tick,
    input  logic [1:0][BYTE_W-1:0] per_buf,
    input  logic [1:0][BYTE_W-1:0] duty_buf,
    output logic [1:0]             pin
);

    localparam int W2 = 2 * BYTE_W;

    logic [1:0][BYTE_W-1:0] cnt_q;
    logic [1:0][BYTE_W-1:0] per_q;
    logic [1:0][BYTE_W-1:0] duty_q;

    logic [1:0][BYTE_W:0]   lane_inc;
    logic [1:0]             lane_wrap;
    logic [1:0]             lane_act;
    logic [W2-1:0]          wide_cnt;
    logic [W2-1:0]          wide_per;
    logic [W2-1:0]          wide_duty;
    logic [W2:0]            wide_inc;
    logic                   wide_wrap;
    logic                   wide_act;

    // Next-count and wrap detection for both lane and fused views
    always_comb begin
        for (int i = 0; i < 2; i++) begin
            lane_inc[i]  = {1'b0, cnt_q[i]} + (BYTE_W+1)'(1);
            lane_wrap[i] = lane_inc[i] >= {1'b0, per_q[i]};
            lane_act[i]  = cnt_q[i] < duty_q[i];
        end
        wide_cnt  = {cnt_q[0], cnt_q[1]};
        wide_per  = {per_q[0], per_q[1]};
        wide_duty = {duty_q[0], duty_q[1]};
        wide_inc  = {1'b0, wide_cnt} + (W2+1)'(1);
        wide_wrap = wide_inc >= {1'b0, wide_per};
        wide_act  = wide_cnt < wide_duty;
    end

    // Counters and working settings, loaded at wrap or while stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            per_q  <= '0;
            duty_q <= '0;
        end else if (fuse) begin
            if (!en[1]) begin
                cnt_q  <= '0;
                per_q  <= per_buf;
                duty_q <= duty_buf;
            end else if (tick[1]) begin
                if (wide_wrap) begin
                    cnt_q  <= '0;
                    per_q  <= per_buf;
                    duty_q <= duty_buf;
                end else begin
                    {cnt_q[0], cnt_q[1]} <= wide_inc[W2-1:0];
                end
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (!en[i]) begin
                    cnt_q[i]  <= '0;
                    per_q[i]  <= per_buf[i];
                    duty_q[i] <= duty_buf[i];
                end else if (tick[i]) begin
                    if (lane_wrap[i]) begin
                        cnt_q[i]  <= '0;
                        per_q[i]  <= per_buf[i];
                        duty_q[i] <= duty_buf[i];
                    end else begin
                        cnt_q[i] <= lane_inc[i][BYTE_W-1:0];
                    end
                end
            end
        end
    end

    // Pin levels: active level while count is below duty, else inactive
    always_comb begin
        if (fuse) begin
            pin[0] = ~pol[0];
            pin[1] = (en[1] && wide_act) ? pol[1] : ~pol[1];
        end else begin
            for (int i = 0; i < 2; i++) begin
                pin[i] = (en[i] && lane_act[i]) ? pol[i] : ~pol[i];
            end
        end
    end

endmodule

// File: rtl/pwm4_unit.sv
// Module: pwm4_unit (top)
// Four-channel modulator with a write-only register port. Holds the
// control registers and the period/duty buffers, selects each channel's
// tick and builds the channel pairs. Assumes 2*NUM_CH select bits and
// NUM_CH enable bits fit in BYTE_W, and DIV_W is at most 4.
module pwm4_unit
    import pwm4_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int DIV_W     = 3,
    parameter int NUM_PAIRS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [3:0]                    wr_addr,
    input  logic [BYTE_W-1:0]             wr_data,
    output logic [2*NUM_PAIRS-1:0]        pwm_out
);

    localparam int NUM_CH    = 2 * NUM_PAIRS;
    localparam int DUTY_BASE = PER_BASE + NUM_CH;

    logic [NUM_CH-1:0]              en_q;
    logic [NUM_CH-1:0]              pol_q;
    logic [NUM_PAIRS-1:0]           fuse_q;
    logic [DIV_W-1:0]               div_a_q;
    logic [DIV_W-1:0]               div_b_q;
    logic [BYTE_W-1:0]              scale_q;
    clk_src_e                       sel_q [NUM_CH];
    logic [NUM_CH-1:0][BYTE_W-1:0]  per_buf;
    logic [NUM_CH-1:0][BYTE_W-1:0]  duty_buf;

    logic                           tick_a;
    logic                           tick_b;
    logic                           tick_s;
    logic [NUM_CH-1:0]              ch_tick;

    // Control register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            pol_q   <= '0;
            fuse_q  <= '0;
            div_a_q <= '0;
            div_b_q <= '0;
            scale_q <= '0;
            for (int i = 0; i < NUM_CH; i++) sel_q[i] <= SRC_A;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_ENABLE: en_q    <= wr_data[NUM_CH-1:0];
                ADR_POLAR:  pol_q   <= wr_data[NUM_CH-1:0];
                ADR_FUSE:   fuse_q  <= wr_data[NUM_PAIRS-1:0];
                ADR_PRESC: begin
                    div_a_q <= wr_data[DIV_W-1:0];
                    div_b_q <= wr_data[4 +: DIV_W];
                end
                ADR_SCALE:  scale_q <= wr_data;
                ADR_SELECT: begin
                    for (int i = 0; i < NUM_CH; i++)
                        sel_q[i] <= clk_src_e'(wr_data[2*i +: 2]);
                end
                default: ;
            endcase
        end
    end

    // Period and duty buffer writes, one address per channel each
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_buf  <= '0;
            duty_buf <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (wr_addr == 4'(PER_BASE + i))  per_buf[i]  <= wr_data;
                if (wr_addr == 4'(DUTY_BASE + i)) duty_buf[i] <= wr_data;
            end
        end
    end

    pwm4_prescaler #(
        .DIV_W   (DIV_W),
        .SCALE_W (BYTE_W)
    ) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_a  (div_a_q),
        .div_b  (div_b_q),
        .scale  (scale_q),
        .tick_a (tick_a),
        .tick_b (tick_b),
        .tick_s (tick_s)
    );

    // Per-channel tick selection from the three sources
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            case (sel_q[i])
                SRC_B:   ch_tick[i] = tick_b;
                SRC_S:   ch_tick[i] = tick_s;
                default: ch_tick[i] = tick_a;
            endcase
        end
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        pwm4_pair #(
            .BYTE_W (BYTE_W)
        ) u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .fuse     (fuse_q[p]),
            .en       (en_q[2*p +: 2]),
            .pol      (pol_q[2*p +: 2]),
            .tick     (ch_tick[2*p +: 2]),
            .per_buf  (per_buf[2*p +: 2]),
            .duty_buf (duty_buf[2*p +: 2]),
            .pin      (pwm_out[2*p +: 2])
        );
    end

endmodule

// File: rtl/pwm4_unit_chk.sv
// Module: pwm4_unit_chk
// Property checker bound into pwm4_unit. Watches the registered controls,
// the prescaler ticks and the output pins.
module pwm4_unit_chk #(
    parameter int NUM_CH    = 4,
    parameter int NUM_PAIRS = 2,
    parameter int DIV_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CH-1:0]    en_q,
    input logic [NUM_CH-1:0]    pol_q,
    input logic [NUM_PAIRS-1:0] fuse_q,
    input logic [DIV_W-1:0]     div_a_q,
    input logic [DIV_W-1:0]     div_b_q,
    input logic                 tick_a,
    input logic                 tick_b,
    input logic                 tick_s,
    input logic [NUM_CH-1:0]    pwm_out
);

    // R1: exponent zero means a tick on every cycle
    a_r1_tick_a_full: assert property (@(posedge clk) disable iff (!rst_n)
        div_a_q == '0 |-> tick_a);
    a_r1_tick_b_full: assert property (@(posedge clk) disable iff (!rst_n)
        div_b_q == '0 |-> tick_b);
    // R1: S is derived from A, so it can only fire with A
    a_r1_s_within_a: assert property (@(posedge clk) disable iff (!rst_n)
        tick_s |-> tick_a);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // R8: a stopped channel shows its inactive level
        a_r8_stopped_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !en_q[i] |-> pwm_out[i] == ~pol_q[i]);
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pr
        // R9: the lower pin of a fused pair stays inactive
        a_r9_low_pin_idle: assert property (@(posedge clk) disable iff (!rst_n)
            fuse_q[p] |-> pwm_out[2*p] == ~pol_q[2*p]);
    end

endmodule

bind pwm4_unit pwm4_unit_chk #(
    .NUM_CH    (NUM_CH),
    .NUM_PAIRS (NUM_PAIRS),
    .DIV_W     (DIV_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_q    (en_q),
    .pol_q   (pol_q),
    .fuse_q  (fuse_q),
    .div_a_q (div_a_q),
    .div_b_q (div_b_q),
    .tick_a  (tick_a),
    .tick_b  (tick_b),
    .tick_s  (tick_s),
    .pwm_out (pwm_out)
);

// File: tb/sim_pwm4_unit.sv
// Directed bench for pwm4_unit: one task per scenario, each checking its
// own results by counting active cycles and rising edges in windows.
module sim_pwm4_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] pwm_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    int highs [4];
    int rises [4];

    always #10 clk = ~clk;

    pwm4_unit u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negedge; the write lands at the next posedge
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Samples W cycles after the current one, per pin
    task automatic measure(input int w);
        logic [3:0] prev;
        prev = pwm_out;
        for (int k = 0; k < 4; k++) begin
            highs[k] = 0;
            rises[k] = 0;
        end
        for (int n = 0; n < w; n++) begin
            @(negedge clk);
            for (int k = 0; k < 4; k++) begin
                if (pwm_out[k]) highs[k]++;
                if (pwm_out[k] && !prev[k]) rises[k]++;
            end
            prev = pwm_out;
        end
    endtask

    task automatic t_reset;
        chk("R10 all pins high after reset", int'(pwm_out), 15);
    endtask

    task automatic t_basic;
        wr(4'h1, 8'h01);
        wr(4'h8, 8'd4);
        wr(4'hC, 8'd1);
        wr(4'h0, 8'h01);
        measure(40);
        chk("R3 ch0 active cycles", highs[0], 10);
        chk("R3 ch0 rising edges", rises[0], 10);
    endtask

    task automatic t_buffer;
        wr(4'h0, 8'h00);
        wr(4'h8, 8'd16);
        wr(4'hC, 8'd4);
        wr(4'h0, 8'h01);
        chk("R6 ch0 starts high at count 0", int'(pwm_out[0]), 1);
        repeat (5) @(negedge clk);
        chk("R3 ch0 low at count 5", int'(pwm_out[0]), 0);
        wr(4'hC, 8'd12);
        chk("R7 new duty held until wrap", int'(pwm_out[0]), 0);
        repeat (16) @(negedge clk);
        chk("R7 new duty after wrap", int'(pwm_out[0]), 1);
        measure(32);
        chk("R7 ch0 active cycles duty 12", highs[0], 24);
        wr(4'h8, 8'd8);
        repeat (20) @(negedge clk);
        measure(16);
        chk("R5 duty above period always active", highs[0], 16);
        chk("R5 no rising edge", rises[0], 0);
    endtask

    task automatic t_polarity;
        wr(4'h9, 8'd5);
        wr(4'hD, 8'd2);
        wr(4'h0, 8'h03);
        measure(50);
        chk("R6 ch1 polarity 0 high cycles", highs[1], 30);
        chk("R6 ch1 polarity 0 rising edges", rises[1], 10);
    endtask

    task automatic t_duty_zero;
        wr(4'hD, 8'd0);
        repeat (10) @(negedge clk);
        measure(20);
        chk("R4 duty 0 stays inactive", highs[1], 20);
        chk("R4 duty 0 no edges", rises[1], 0);
    endtask

    task automatic t_stopped;
        wr(4'h0, 8'h00);
        measure(10);
        chk("R8 stopped ch0 inactive low", highs[0], 0);
        chk("R8 stopped ch1 inactive high", highs[1], 10);
    endtask

    task automatic t_clock_b;
        wr(4'h1, 8'h05);
        wr(4'h3, 8'h20);
        wr(4'h5, 8'h10);
        wr(4'hA, 8'd4);
        wr(4'hE, 8'd1);
        wr(4'h0, 8'h04);
        repeat (20) @(negedge clk);
        measure(64);
        chk("R2 ch2 on tick B active cycles", highs[2], 16);
        chk("R1 tick B every 4 rising edges", rises[2], 4);
    endtask

    task automatic t_clock_s;
        wr(4'h1, 8'h0D);
        wr(4'h5, 8'h90);
        wr(4'h3, 8'h21);
        wr(4'h4, 8'd2);
        wr(4'hB, 8'd2);
        wr(4'hF, 8'd1);
        wr(4'h8, 8'd3);
        wr(4'hC, 8'd1);
        wr(4'h0, 8'h0D);
        repeat (60) @(negedge clk);
        measure(144);
        chk("R1 tick A every 2 ch0 active", highs[0], 48);
        chk("R1 tick A every 2 ch0 edges", rises[0], 24);
        chk("R2 ch2 still on B edges", rises[2], 9);
        chk("R2 ch3 on tick S active", highs[3], 72);
        chk("R1 tick S every 12 ch3 edges", rises[3], 6);
    endtask

    task automatic t_fuse;
        wr(4'h0, 8'h00);
        wr(4'h1, 8'h0F);
        wr(4'h5, 8'h00);
        wr(4'h3, 8'h20);
        wr(4'h2, 8'h03);
        wr(4'h8, 8'h01);
        wr(4'h9, 8'h00);
        wr(4'hC, 8'h00);
        wr(4'hD, 8'h40);
        wr(4'hA, 8'h01);
        wr(4'hB, 8'h00);
        wr(4'hE, 8'h00);
        wr(4'hF, 8'h80);
        wr(4'h0, 8'h0F);
        measure(256);
        chk("R9 pair0 16-bit active cycles", highs[1], 64);
        chk("R9 pair0 one period", rises[1], 1);
        chk("R9 pair1 16-bit active cycles", highs[3], 128);
        chk("R9 pin0 held inactive", highs[0], 0);
        chk("R9 pin2 held inactive", highs[2], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_buffer();
        t_polarity();
        t_duty_zero();
        t_stopped();
        t_clock_b();
        t_clock_s();
        t_fuse();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule